// File: doc/BRIEF.md
# Dual-Port RAM Contention Arbiter

A synchronous two-port memory of 4096 words of 16 bits, with two independent ports, A and B. Each port has its own enable, write enable, address, write data and registered read data. Both ports can read and write any word in any cycle.

When both ports are enabled on the same address, an arbiter picks a winner by arrival order. The port whose enable and address were already present in the previous cycle wins. The later port sees its busy output raised, and its write is suppressed for as long as the contention lasts. If both ports start contending in the same cycle, port A wins.

A mode input selects the role of the busy signals. In master mode the block drives the busy outputs and ignores the busy inputs. In slave mode the busy outputs stay low, and each port's busy input, supplied by an external master device, inhibits that port's writes.

Top module: `dual_port_contention_ram`

## Requirements
- R1: Each port reads and writes any of the 2^ADDR_W words (default 4096 x 16). A write with enable and write enable high at a clock edge stores the word. A read with enable high returns the word on that port's read data after that edge.
- R2: In master mode (mode_master_i = 1), a contention is both enables high with equal addresses. When a contention begins, the port whose enable was high on the same address in the previous cycle wins, and the other port's busy output goes high in that same cycle. Both busy outputs are never high together.
- R3: When a contention begins and neither port held that enabled address in the previous cycle, port A wins and only b_busy_o goes high.
- R4: Busy stays with the same loser for every cycle the contention persists, whatever the write enables do. It drops combinationally in the cycle the addresses differ or either enable goes low. Busy is never high without a contention.
- R5: While a port's busy output is high, its write does not reach the memory. The winner's write in the same cycle is stored.
- R6: A losing port that keeps write enable high stores its word at the first edge at which its busy is low.
- R7: Reads on the losing port are not blocked. Its read data returns the stored word while it is busy.
- R8: In slave mode (mode_master_i = 0), both busy outputs are 0 and a port's busy input high suppresses that port's write. In master mode the busy inputs have no effect.
- R9: A word written by one port at an edge is returned by the other port when it reads that address in a later cycle. A read of an address being written at the same edge returns the previous word.
- R10: After reset, both busy outputs are low and both read data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_master_i | input | 1 | 1: arbitrate and drive busy; 0: take busy as input |
| a_en_i | input | 1 | Port A enable |
| a_we_i | input | 1 | Port A write enable |
| a_addr_i | input | ADDR_W | Port A address |
| a_wdata_i | input | DATA_W | Port A write data |
| a_busy_i | input | 1 | Port A write inhibit in slave mode |
| a_rdata_o | output | DATA_W | Port A read data |
| a_busy_o | output | 1 | Port A lost contention (master mode) |
| b_en_i | input | 1 | Port B enable |
| b_we_i | input | 1 | Port B write enable |
| b_addr_i | input | ADDR_W | Port B address |
| b_wdata_i | input | DATA_W | Port B write data |
| b_busy_i | input | 1 | Port B write inhibit in slave mode |
| b_rdata_o | output | DATA_W | Port B read data |
| b_busy_o | output | 1 | Port B lost contention (master mode) |

## Verification
The hardest situation to reach is a contention decided by arrival order rather than by the tie rule. One port must hold an enabled address for a cycle before the other moves onto it. A different sequence is needed for each direction of the win. The stimulus table steps through these cases in order. Port A parks on an address before B joins; port B parks while A moves across from a neighbouring word; one port switches its enable on while the other already holds the address. The final contents are then read back through both ports and compared with a model that applies only the writes the requirements allow.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  localparam int unsigned NUM_PORTS = 2;
  localparam int unsigned PORT_A = 0;
  localparam int unsigned PORT_B = 1;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_A    = 2'd1,
    OWN_B    = 2'd2
  } owner_e;
endpackage

// File: rtl/dpc_arbiter.sv
module dpc_arbiter
  import dpc_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                mode_master_i,
  input  logic [NUM_PORTS-1:0]                en_i,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0]    addr_i,
  output logic [NUM_PORTS-1:0]                lose_o
);
  logic [NUM_PORTS-1:0]             en_q;
  logic [NUM_PORTS-1:0][ADDR_W-1:0] addr_q;
  logic [NUM_PORTS-1:0]             held;
  owner_e                           owner_q, owner_d, winner;
  logic                             match;

  assign match = en_i[PORT_A] & en_i[PORT_B] & (addr_i[PORT_A] == addr_i[PORT_B]);

  // a port "held" the location if it sat on it, enabled, last cycle
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_held
    assign held[p] = en_q[p] & (addr_q[p] == addr_i[p]);
  end

  always_comb begin
    winner = OWN_NONE;
    if (match) begin
      if (owner_q != OWN_NONE)                   winner = owner_q;
      else if (held[PORT_B] && !held[PORT_A])    winner = OWN_B;
      else                                       winner = OWN_A;  // earlier A or tie
    end
    owner_d = mode_master_i ? winner : OWN_NONE;
  end

  assign lose_o[PORT_A] = mode_master_i & (winner == OWN_B);
  assign lose_o[PORT_B] = mode_master_i & (winner == OWN_A);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '0;
      addr_q  <= '0;
      owner_q <= OWN_NONE;
    end else begin
      en_q    <= en_i;
      addr_q  <= addr_i;
      owner_q <= owner_d;
    end
  end
endmodule

// File: rtl/dpc_port_gate.sv
module dpc_port_gate (
  input  logic mode_master_i,
  input  logic en_i,
  input  logic we_i,
  input  logic arb_lose_i,
  input  logic ext_busy_i,
  output logic wr_en_o,
  output logic busy_o
);
  logic inhibit;

  assign inhibit = mode_master_i ? arb_lose_i : ext_busy_i;
  assign busy_o  = mode_master_i & arb_lose_i;
  assign wr_en_o = en_i & we_i & ~inhibit;
endmodule

// File: rtl/dpc_mem_2p.sv
module dpc_mem_2p
  import dpc_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 16
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [NUM_PORTS-1:0]                rd_en_i,
  input  logic [NUM_PORTS-1:0]                wr_en_i,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0]    addr_i,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0]    wdata_i,
  output logic [NUM_PORTS-1:0][DATA_W-1:0]    rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (wr_en_i[p]) mem_q[addr_i[p]] <= wdata_i[p];
    end
  end

  // read-first: a read at a write edge sees the previous word
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rd
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         rdata_o[p] <= '0;
      else if (rd_en_i[p]) rdata_o[p] <= mem_q[addr_i[p]];
    end
  end
endmodule

// File: rtl/dual_port_contention_ram.sv
module dual_port_contention_ram
  import dpc_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_master_i,
  input  logic              a_en_i,
  input  logic              a_we_i,
  input  logic [ADDR_W-1:0] a_addr_i,
  input  logic [DATA_W-1:0] a_wdata_i,
  input  logic              a_busy_i,
  output logic [DATA_W-1:0] a_rdata_o,
  output logic              a_busy_o,
  input  logic              b_en_i,
  input  logic              b_we_i,
  input  logic [ADDR_W-1:0] b_addr_i,
  input  logic [DATA_W-1:0] b_wdata_i,
  input  logic              b_busy_i,
  output logic [DATA_W-1:0] b_rdata_o,
  output logic              b_busy_o
);
  logic [NUM_PORTS-1:0]             en, we, ext_busy, lose, wr_en, busy;
  logic [NUM_PORTS-1:0][ADDR_W-1:0] addr;
  logic [NUM_PORTS-1:0][DATA_W-1:0] wdata, rdata;

  assign en       = {b_en_i, a_en_i};
  assign we       = {b_we_i, a_we_i};
  assign ext_busy = {b_busy_i, a_busy_i};
  assign addr     = {b_addr_i, a_addr_i};
  assign wdata    = {b_wdata_i, a_wdata_i};

  dpc_arbiter #(.ADDR_W(ADDR_W)) i_arbiter (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .mode_master_i (mode_master_i),
    .en_i          (en),
    .addr_i        (addr),
    .lose_o        (lose)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_gate
    dpc_port_gate i_gate (
      .mode_master_i (mode_master_i),
      .en_i          (en[p]),
      .we_i          (we[p]),
      .arb_lose_i    (lose[p]),
      .ext_busy_i    (ext_busy[p]),
      .wr_en_o       (wr_en[p]),
      .busy_o        (busy[p])
    );
  end

  dpc_mem_2p #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_en_i (en),
    .wr_en_i (wr_en),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata)
  );

  assign a_rdata_o = rdata[PORT_A];
  assign b_rdata_o = rdata[PORT_B];
  assign a_busy_o  = busy[PORT_A];
  assign b_busy_o  = busy[PORT_B];
endmodule

// File: rtl/dpc_checker.sv
module dpc_checker #(
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mode_master_i,
  input logic              a_en_i,
  input logic [ADDR_W-1:0] a_addr_i,
  input logic              a_busy_o,
  input logic              b_en_i,
  input logic [ADDR_W-1:0] b_addr_i,
  input logic              b_busy_o
);
  logic started_q;
  logic match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) started_q <= 1'b0;
    else         started_q <= 1'b1;
  end

  assign match = a_en_i && b_en_i && (a_addr_i == b_addr_i);

  assert_one_loser_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_master_i |-> !(a_busy_o && b_busy_o));

  assert_later_a_loses_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && mode_master_i && match && !$past(match)
     && $past(b_en_i) && ($past(b_addr_i) == b_addr_i)
     && !($past(a_en_i) && ($past(a_addr_i) == a_addr_i))) |-> a_busy_o);

  assert_tie_a_wins_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && mode_master_i && match
     && !($past(a_en_i) && ($past(a_addr_i) == a_addr_i))
     && !($past(b_en_i) && ($past(b_addr_i) == b_addr_i))) |-> (b_busy_o && !a_busy_o));

  assert_busy_needs_match_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_busy_o || b_busy_o) |-> match);

  assert_busy_sticks_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && mode_master_i && $past(mode_master_i) && match && $past(match))
      |-> (a_busy_o == $past(a_busy_o)) && (b_busy_o == $past(b_busy_o)));

  assert_slave_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_master_i |-> (!a_busy_o && !b_busy_o));
endmodule

bind dual_port_contention_ram dpc_checker #(.ADDR_W(ADDR_W)) i_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .mode_master_i (mode_master_i),
  .a_en_i        (a_en_i),
  .a_addr_i      (a_addr_i),
  .a_busy_o      (a_busy_o),
  .b_en_i        (b_en_i),
  .b_addr_i      (b_addr_i),
  .b_busy_o      (b_busy_o)
);

// File: tb/test_dual_port_contention_ram.sv
module test_dual_port_contention_ram;
  localparam int unsigned AW = 12;
  localparam int unsigned DW = 16;

  typedef struct packed {
    logic          m;
    logic          ae, aw;
    logic [AW-1:0] aa;
    logic [DW-1:0] ad;
    logic          abi;
    logic          be, bw;
    logic [AW-1:0] ba;
    logic [DW-1:0] bd;
    logic          bbi;
    logic          xa, xb;
  } vec_t;

  localparam int NV = 15;
  // m ae aw aa ad abi | be bw ba bd bbi | exp busy a,b
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1,1'b1,12'h010,16'h1111,1'b0, 1'b0,1'b0,12'h000,16'h0000,1'b0, 1'b0,1'b0},
    '{1'b1, 1'b1,1'b1,12'h010,16'h2222,1'b0, 1'b1,1'b1,12'h010,16'h3333,1'b0, 1'b0,1'b1},
    '{1'b1, 1'b1,1'b1,12'h010,16'h2222,1'b0, 1'b1,1'b1,12'h010,16'h3333,1'b0, 1'b0,1'b1},
    '{1'b1, 1'b0,1'b0,12'h010,16'h0000,1'b0, 1'b1,1'b1,12'h010,16'h3333,1'b0, 1'b0,1'b0},
    '{1'b1, 1'b1,1'b1,12'h020,16'h4444,1'b0, 1'b1,1'b1,12'h020,16'h5555,1'b0, 1'b0,1'b1},
    '{1'b1, 1'b1,1'b1,12'h021,16'h6666,1'b0, 1'b1,1'b1,12'h020,16'h5555,1'b0, 1'b0,1'b0},
    '{1'b1, 1'b1,1'b1,12'h020,16'h7777,1'b0, 1'b1,1'b1,12'h020,16'h8888,1'b0, 1'b1,1'b0},
    '{1'b1, 1'b1,1'b1,12'h020,16'h7777,1'b0, 1'b1,1'b0,12'h020,16'h0000,1'b0, 1'b1,1'b0},
    '{1'b1, 1'b1,1'b1,12'h020,16'h7777,1'b0, 1'b0,1'b0,12'h020,16'h0000,1'b0, 1'b0,1'b0},
    '{1'b1, 1'b1,1'b1,12'h030,16'h1357,1'b0, 1'b0,1'b1,12'h030,16'h2468,1'b0, 1'b0,1'b0},
    '{1'b1, 1'b1,1'b1,12'h030,16'h1357,1'b0, 1'b1,1'b1,12'h030,16'h2468,1'b0, 1'b0,1'b1},
    '{1'b0, 1'b1,1'b1,12'h040,16'hAAAA,1'b1, 1'b1,1'b1,12'h040,16'hBBBB,1'b0, 1'b0,1'b0},
    '{1'b0, 1'b1,1'b1,12'h041,16'hCCCC,1'b0, 1'b1,1'b1,12'h030,16'hDDDD,1'b1, 1'b0,1'b0},
    '{1'b1, 1'b0,1'b0,12'h000,16'h0000,1'b1, 1'b1,1'b1,12'h050,16'hEEEE,1'b1, 1'b0,1'b0},
    '{1'b1, 1'b1,1'b1,12'h060,16'h0101,1'b0, 1'b1,1'b1,12'h061,16'h0202,1'b0, 1'b0,1'b0}
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          mode_master_i = 1'b1;
  logic          a_en_i = 0, a_we_i = 0, a_busy_i = 0;
  logic          b_en_i = 0, b_we_i = 0, b_busy_i = 0;
  logic [AW-1:0] a_addr_i = '0, b_addr_i = '0;
  logic [DW-1:0] a_wdata_i = '0, b_wdata_i = '0;
  logic [DW-1:0] a_rdata_o, b_rdata_o;
  logic          a_busy_o, b_busy_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [DW-1:0] ref_mem [int];

  always #2 clk_i = ~clk_i;

  dual_port_contention_ram #(.ADDR_W(AW), .DATA_W(DW)) i_dual_port_contention_ram (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    a_en_i = 0; a_we_i = 0; b_en_i = 0; b_we_i = 0; a_busy_i = 0; b_busy_i = 0;
    mode_master_i = 1'b1;
  endtask

  task automatic read_port(input bit port_b, input logic [AW-1:0] adr, output logic [DW-1:0] dat);
    @(negedge clk_i);
    idle();
    if (port_b) begin b_en_i = 1; b_addr_i = adr; end
    else        begin a_en_i = 1; a_addr_i = adr; end
    @(posedge clk_i); #1;
    dat = port_b ? b_rdata_o : a_rdata_o;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    logic [DW-1:0] rd;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    chk("R10 a_busy_o after reset", 32'(a_busy_o), 0);
    chk("R10 b_busy_o after reset", 32'(b_busy_o), 0);
    chk("R10 a_rdata_o after reset", 32'(a_rdata_o), 0);
    chk("R10 b_rdata_o after reset", 32'(b_rdata_o), 0);

    // stimulus table: busy checked combinationally before each edge
    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      mode_master_i = VECS[i].m;
      a_en_i = VECS[i].ae; a_we_i = VECS[i].aw; a_addr_i = VECS[i].aa;
      a_wdata_i = VECS[i].ad; a_busy_i = VECS[i].abi;
      b_en_i = VECS[i].be; b_we_i = VECS[i].bw; b_addr_i = VECS[i].ba;
      b_wdata_i = VECS[i].bd; b_busy_i = VECS[i].bbi;
      #1;
      chk($sformatf("R2 R3 R4 R8 a_busy_o row %0d", i), 32'(a_busy_o), 32'(VECS[i].xa));
      chk($sformatf("R2 R3 R4 R8 b_busy_o row %0d", i), 32'(b_busy_o), 32'(VECS[i].xb));
      // reference: a port writes unless busy (master) or busy input (slave)
      if (VECS[i].ae && VECS[i].aw && !(VECS[i].m ? VECS[i].xa : VECS[i].abi))
        ref_mem[int'(VECS[i].aa)] = VECS[i].ad;
      if (VECS[i].be && VECS[i].bw && !(VECS[i].m ? VECS[i].xb : VECS[i].bbi))
        ref_mem[int'(VECS[i].ba)] = VECS[i].bd;
    end

    // R7: loser keeps reading; R9: read-first at write edge, then cross visibility
    @(negedge clk_i);
    idle();
    a_en_i = 1; a_addr_i = 12'h060;
    @(negedge clk_i);
    a_we_i = 1; a_wdata_i = 16'hC0DE;
    b_en_i = 1; b_addr_i = 12'h060;
    #1;
    chk("R7 b_busy_o while reading", 32'(b_busy_o), 1);
    @(posedge clk_i); #1;
    chk("R7 R9 loser read returns old word", 32'(b_rdata_o), 32'h0101);
    ref_mem[32'h060] = 16'hC0DE;
    @(negedge clk_i);
    a_en_i = 0; a_we_i = 0;
    #1;
    chk("R4 busy released when winner disables", 32'(b_busy_o), 0);
    @(posedge clk_i); #1;
    chk("R9 cross-port read of new word", 32'(b_rdata_o), 32'hC0DE);

    // R1 R5 R6 R8: final contents through both ports
    foreach (ref_mem[k]) begin
      read_port(1'b0, AW'(k), rd);
      chk($sformatf("R1 R5 R6 R8 port A word %03h", k), 32'(rd), 32'(ref_mem[k]));
      read_port(1'b1, AW'(k), rd);
      chk($sformatf("R1 R5 R6 R8 port B word %03h", k), 32'(rd), 32'(ref_mem[k]));
    end

    @(negedge clk_i);
    idle();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule